// File: doc/BRIEF.md
# Line-Group Video FIFO Distributor

This block sits on a progressive video input and splits each frame into horizontal bands. It watches the horizontal and vertical sync strobes, counts video lines, and sends every pixel of the active video to one of several on-chip FIFOs. Each FIFO covers a band of four lines. The selected FIFO moves on to the next one after every fourth line and returns to the first FIFO after the last. Each FIFO is read by its own processing element, so the processors work on separate image regions at the same time.

A FIFO still holds the results of the previous pass, and those must be read out before new pixels may land in it. The processing element reads its FIFO through a dedicated read port until the FIFO is empty. It then pulses a per-FIFO drain acknowledge. This arms that FIFO for its next band. The arm is consumed when the band ends. A pixel offered to a FIFO that is not armed is discarded. A pixel offered to a full FIFO is also discarded, and it sets a sticky overflow flag for that FIFO.

Top module: `linegroup_fifo_dist`

## Requirements
- R1: A synchronous active-low reset sets `grp_sel` to 0, empties every FIFO (`rd_empty` all ones), clears all overflow flags and all arms, and holds `wr_en` at zero.
- R2: A rising edge on `vsync` returns `grp_sel` to 0 and restarts the line count, even in the middle of a band.
- R3: Each rising edge of `hsync` ends one line. After the fourth line-end inside a band, `grp_sel` advances by one, and it wraps from NUM_Q-1 back to 0.
- R4: A pixel is stored only in a cycle with `pix_valid` high. It goes only into the FIFO whose index equals `grp_sel`, and at most one bit of `wr_en` is set in any cycle.
- R5: A pixel offered to a FIFO that has not been armed by a `drain_ack` pulse for that FIFO is discarded. The FIFO contents stay unchanged.
- R6: A FIFO's arm is cleared by the line-end that completes its band. Pixels offered to it later, until a new `drain_ack`, are discarded.
- R7: Each FIFO returns its data in write order. `rd_data` shows the head entry while `rd_empty` is low, and a `rd_en` pulse removes it.
- R8: A pixel offered to a full, armed FIFO is discarded and sets that FIFO's `ovf` bit. The bit stays set until reset, and the stored data is not altered.
- R9: All FIFOs can be read in the same cycle, independently of each other and of the write side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | Vertical sync; a rising edge starts a frame |
| hsync | input | 1 | Horizontal sync; a rising edge ends a line |
| pix_valid | input | 1 | High during active video pixels |
| pix_data | input | DATA_W | Pixel value |
| drain_ack | input | NUM_Q | Per-FIFO pulse: previous results fully read, arm for next band |
| rd_en | input | NUM_Q | Per-FIFO pop strobe from the processing element |
| rd_data | output | NUM_Q*DATA_W | Head entry of each FIFO, FIFO q in bits q*DATA_W upward |
| rd_empty | output | NUM_Q | Per-FIFO empty flag |
| wr_en | output | NUM_Q | Per-FIFO write strobe for the current pixel |
| wr_data | output | DATA_W | Pixel value presented to the FIFOs |
| grp_sel | output | clog2(NUM_Q) | Index of the FIFO receiving the current band |
| ovf | output | NUM_Q | Sticky per-FIFO overflow flags |

## Verification
The bench walks sync sequences through the wrap from the last FIFO to the first and puts a vertical sync in the middle of a band. A selector that counted three or five lines, forgot to wrap, or ignored the frame restart would land on the wrong FIFO. Pixels are offered before any acknowledge and again after a band has consumed its arm. A design that kept the arm across bands would leave extra entries in the FIFO, and these show up when it is drained. A FIFO is filled to depth and then given one more pixel. Losing the sticky flag, or overwriting the oldest entry, changes the drained sequence. Two FIFOs are then popped in the same cycle to catch shared read logic.

// File: rtl/lgd_pkg.sv
// Package: shared helpers for the line-group distributor.
package lgd_pkg;
    // Width needed to index n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lgd_line_tracker.sv
// Line tracker: finds the sync edges, counts lines inside a band and
// keeps the index of the FIFO that owns the current band.
// Assumes sync inputs are already in the pixel-clock domain.
module lgd_line_tracker
    import lgd_pkg::*;
#(
    parameter int NUM_Q         = 8,
    parameter int LINES_PER_GRP = 4,
    localparam int SW = idx_bits(NUM_Q),
    localparam int CW = idx_bits(LINES_PER_GRP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          hsync,
    output logic [SW-1:0] sel_o,
    output logic          grp_end_o
);
    logic          vs_q, hs_q;
    logic [CW-1:0] line_cnt;
    logic          vs_rise, hs_rise;

    // Edge detection against the previous sample.
    always_comb begin
        vs_rise   = vsync && !vs_q;
        hs_rise   = hsync && !hs_q;
        grp_end_o = hs_rise && !vs_rise && (line_cnt == CW'(LINES_PER_GRP - 1));
    end

    // Line counter and band selector; frame start has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q     <= 1'b0;
            hs_q     <= 1'b0;
            line_cnt <= '0;
            sel_o    <= '0;
        end else begin
            vs_q <= vsync;
            hs_q <= hsync;
            if (vs_rise) begin
                line_cnt <= '0;
                sel_o    <= '0;
            end else if (hs_rise) begin
                if (line_cnt == CW'(LINES_PER_GRP - 1)) begin
                    line_cnt <= '0;
                    sel_o    <= (sel_o == SW'(NUM_Q - 1)) ? '0 : sel_o + 1'b1;
                end else begin
                    line_cnt <= line_cnt + 1'b1;
                end
            end
        end
    end

    assert_vsync_home_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (sel_o == '0));
    assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o <= SW'(NUM_Q - 1));
endmodule

// File: rtl/lgd_write_gate.sv
// Write gate: holds one drain arm per FIFO and forms the per-FIFO write
// strobes and sticky overflow flags. Assumes at most one band ends per cycle.
module lgd_write_gate
    import lgd_pkg::*;
#(
    parameter int NUM_Q = 8,
    localparam int SW = idx_bits(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    sel_i,
    input  logic             grp_end_i,
    input  logic             pix_valid,
    input  logic [NUM_Q-1:0] drain_ack,
    input  logic [NUM_Q-1:0] full_i,
    output logic [NUM_Q-1:0] wr_en_o,
    output logic [NUM_Q-1:0] ovf_o
);
    logic [NUM_Q-1:0] armed;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_gate
        logic hit;
        // This FIFO is the target of the current pixel.
        always_comb hit = pix_valid && (sel_i == SW'(q)) && armed[q];
        always_comb wr_en_o[q] = hit && !full_i[q];

        // Arm on acknowledge; the band end consumes the arm.
        always_ff @(posedge clk) begin
            if (!rst_n)                              armed[q] <= 1'b0;
            else if (drain_ack[q])                   armed[q] <= 1'b1;
            else if (grp_end_i && sel_i == SW'(q))   armed[q] <= 1'b0;
        end

        // Sticky overflow on a write attempt into a full FIFO.
        always_ff @(posedge clk) begin
            if (!rst_n)                 ovf_o[q] <= 1'b0;
            else if (hit && full_i[q])  ovf_o[q] <= 1'b1;
        end

        assert_ovf_from_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_o[q]) |-> $past(full_i[q]));
    end

    assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o != '0) |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));
endmodule

// File: rtl/lgd_queue.sv
// Queue: synchronous FIFO with show-ahead read. A write to a full queue
// or a read from an empty queue is ignored. Depth need not be a power of two.
module lgd_queue
    import lgd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW = idx_bits(DEPTH),
    localparam int CW = idx_bits(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;
    logic              do_wr, do_rd;

    // Flags and accepted operations.
    always_comb begin
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
        do_wr = wr && !full;
        do_rd = rd && !empty;
        rdata = mem[rptr];
    end

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr);
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_pop_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !empty && !wr) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/linegroup_fifo_dist.sv
// Top: steers bands of video lines into per-processor FIFOs.
// Assumes pixels of one band fit in DEPTH = LINES_PER_GRP * MAX_PIX.
module linegroup_fifo_dist
    import lgd_pkg::*;
#(
    parameter int NUM_Q         = 8,
    parameter int DATA_W        = 8,
    parameter int LINES_PER_GRP = 4,
    parameter int MAX_PIX       = 16,
    localparam int DEPTH = LINES_PER_GRP * MAX_PIX,
    localparam int SW    = idx_bits(NUM_Q)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vsync,
    input  logic                    hsync,
    input  logic                    pix_valid,
    input  logic [DATA_W-1:0]       pix_data,
    input  logic [NUM_Q-1:0]        drain_ack,
    input  logic [NUM_Q-1:0]        rd_en,
    output logic [NUM_Q*DATA_W-1:0] rd_data,
    output logic [NUM_Q-1:0]        rd_empty,
    output logic [NUM_Q-1:0]        wr_en,
    output logic [DATA_W-1:0]       wr_data,
    output logic [SW-1:0]           grp_sel,
    output logic [NUM_Q-1:0]        ovf
);
    logic             grp_end;
    logic [NUM_Q-1:0] q_full;

    // Pixel value is shared by all FIFOs.
    always_comb wr_data = pix_data;

    lgd_line_tracker #(.NUM_Q(NUM_Q), .LINES_PER_GRP(LINES_PER_GRP)) u_track (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .sel_o(grp_sel), .grp_end_o(grp_end)
    );

    lgd_write_gate #(.NUM_Q(NUM_Q)) u_gate (
        .clk(clk), .rst_n(rst_n), .sel_i(grp_sel), .grp_end_i(grp_end),
        .pix_valid(pix_valid), .drain_ack(drain_ack), .full_i(q_full),
        .wr_en_o(wr_en), .ovf_o(ovf)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        lgd_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en[q]), .wdata(pix_data),
            .rd(rd_en[q]), .rdata(rd_data[q*DATA_W +: DATA_W]),
            .empty(rd_empty[q]), .full(q_full[q])
        );
    end
endmodule

// File: tb/linegroup_fifo_dist_bench.sv
module linegroup_fifo_dist_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int LG = 4;
    localparam int MP = 2;
    localparam int DEPTH = LG * MP;

    // Table entry: {vsync pulse, hsync pulses, expected grp_sel}.
    localparam int NV = 11;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 4'd0, 4'd0}, {1'b0, 4'd3, 4'd0}, {1'b0, 4'd1, 4'd1},
        {1'b0, 4'd4, 4'd2}, {1'b0, 4'd4, 4'd3}, {1'b0, 4'd4, 4'd0},
        {1'b0, 4'd2, 4'd0}, {1'b1, 4'd0, 4'd0}, {1'b0, 4'd3, 4'd0},
        {1'b0, 4'd1, 4'd1}, {1'b1, 4'd0, 4'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, vsync = 1'b0, hsync = 1'b0, pix_valid = 1'b0;
    logic [DW-1:0]   pix_data = '0;
    logic [N-1:0]    drain_ack = '0, rd_en = '0;
    logic [N*DW-1:0] rd_data;
    logic [N-1:0]    rd_empty, wr_en, ovf;
    logic [DW-1:0]   wr_data;
    logic [1:0]      grp_sel;
    int total = 0, bad = 0;
    logic [N-1:0] wr_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    linegroup_fifo_dist #(.NUM_Q(N), .DATA_W(DW), .LINES_PER_GRP(LG), .MAX_PIX(MP)) u_linegroup_fifo_dist (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .pix_valid(pix_valid),
        .pix_data(pix_data), .drain_ack(drain_ack), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .wr_en(wr_en), .wr_data(wr_data), .grp_sel(grp_sel), .ovf(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hs_pulse();
        @(negedge clk) hsync = 1'b1;
        @(negedge clk) hsync = 1'b0;
        #1;
    endtask

    task automatic vs_pulse();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        #1;
    endtask

    task automatic ack(input int q);
        @(negedge clk) drain_ack[q] = 1'b1;
        @(negedge clk) drain_ack = '0;
        #1;
    endtask

    task automatic put(input logic valid, input logic [DW-1:0] d);
        @(negedge clk) begin pix_valid = valid; pix_data = d; end
        #1 wr_seen = wr_en;
        @(negedge clk) pix_valid = 1'b0;
        #1;
    endtask

    task automatic pop(input int q, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        #1 chk(req, int'(rd_empty[q]), 0);
        chk(req, int'(rd_data[q*DW +: DW]), int'(exp));
        rd_en[q] = 1'b1;
        @(negedge clk) rd_en = '0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 sel", int'(grp_sel), 0);
        chk("R1 empty", int'(rd_empty), 4'hF);
        chk("R1 ovf", int'(ovf), 0);
        chk("R1 wr_en", int'(wr_en), 0);
        @(negedge clk) rst_n = 1'b1;

        // R2 R3 table walk of sync sequences
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][8]) vs_pulse();
            for (int k = 0; k < int'(VEC[i][7:4]); k++) hs_pulse();
            chk($sformatf("R3/R2 vec%0d sel", i), int'(grp_sel), int'(VEC[i][3:0]));
        end

        // R5 unarmed FIFO drops the pixel
        put(1'b1, 8'h11);
        chk("R5 wr_en unarmed", int'(wr_seen), 0);
        chk("R5 still empty", int'(rd_empty[0]), 1);

        // R4 valid gating and target selection
        ack(0);
        put(1'b0, 8'h55);
        chk("R4 invalid no write", int'(rd_empty[0]), 1);
        put(1'b1, 8'hA1);
        chk("R4 wr_en target", int'(wr_seen), 1);
        put(1'b1, 8'hA2);
        chk("R4 others empty", int'(rd_empty[3:1]), 3'b111);

        // R6 band end consumes the arm
        for (int k = 0; k < LG; k++) hs_pulse();
        chk("R6 sel moved", int'(grp_sel), 1);
        vs_pulse();
        put(1'b1, 8'hB0);
        chk("R6 wr_en after band", int'(wr_seen), 0);
        // R7 order, and B0 must be absent
        pop(0, 8'hA1, "R7 head1");
        pop(0, 8'hA2, "R7 head2");
        chk("R6 B0 dropped", int'(rd_empty[0]), 1);

        // R9 parallel reads
        ack(0);
        put(1'b1, 8'hC0);
        put(1'b1, 8'hC1);
        for (int k = 0; k < LG; k++) hs_pulse();
        ack(1);
        put(1'b1, 8'hD0);
        @(negedge clk);
        #1 chk("R9 q0 head", int'(rd_data[0 +: DW]), 8'hC0);
        chk("R9 q1 head", int'(rd_data[DW +: DW]), 8'hD0);
        rd_en = 2'b11;
        @(negedge clk) rd_en = '0;
        #1 chk("R9 q0 next", int'(rd_data[0 +: DW]), 8'hC1);
        chk("R9 q1 empty", int'(rd_empty[1]), 1);
        pop(0, 8'hC1, "R9 q0 drain");

        // R8 overflow
        vs_pulse();
        ack(0);
        for (int i = 0; i < DEPTH; i++) put(1'b1, 8'(8'h40 + i));
        chk("R8 no ovf at depth", int'(ovf[0]), 0);
        put(1'b1, 8'h99);
        chk("R8 wr_en when full", int'(wr_seen), 0);
        chk("R8 ovf set", int'(ovf[0]), 1);
        for (int i = 0; i < DEPTH; i++) pop(0, 8'(8'h40 + i), "R8 data intact");
        chk("R8 extra dropped", int'(rd_empty[0]), 1);
        chk("R8 ovf sticky", int'(ovf[0]), 1);
        chk("R8 other ovf", int'(ovf[3:1]), 0);

        // R1 reset mid-operation
        put(1'b1, 8'h77);
        hs_pulse(); hs_pulse(); hs_pulse(); hs_pulse();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R1 re-reset sel", int'(grp_sel), 0);
        chk("R1 re-reset empty", int'(rd_empty), 4'hF);
        chk("R1 re-reset ovf", int'(ovf), 0);
        put(1'b1, 8'h12);
        chk("R1 arms cleared", int'(wr_seen), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule